// File: doc/BRIEF.md
# Condition Test and Loop-Counter Branch Unit

This unit decides whether a conditional branch is taken. A 4-bit condition selector picks one of sixteen tests, which is applied to the negative, zero, overflow and carry flags. Two of the sixteen tests are fixed: always true and always false. The extend flag has no part in any test, so it is not an input.

In plain mode the test result is the branch decision. In loop mode the unit also acts as a counted-loop step. A true condition leaves the loop at once, with the counter untouched. A false condition decrements only the low 16 bits of the 32-bit counter register. The branch back is then taken unless the new low half reads 0xFFFF. Because the exit value is -1 rather than 0, a loop that starts with a count of zero runs its body exactly once, and a loop entered by first jumping to the decrement step runs zero times.

The unit samples its inputs on a start strobe. Its results appear one clock later, on registered outputs. Computing the branch target and fetching instructions are done elsewhere.

Top module: `cond_loop_branch`

## Requirements
- R1: While reset is high, and after it until the first start, cond_true_o, take_o and reg_we_o are 0 and reg_o is 0.
- R2: Selector 0 (always) gives cond_true_o = 1 and selector 1 (never) gives cond_true_o = 0, whatever the flags.
- R3: With flags_i = {N,Z,V,C} (bit 3 = N, bit 0 = C), the selectors evaluate as follows: 2 = !C & !Z, 3 = C | Z, 4 = !C, 5 = C, 6 = !Z, 7 = Z, 8 = !V, 9 = V, 10 = !N, 11 = N.
- R4: The signed selectors evaluate as follows: 12 = (N == V), 13 = (N != V), 14 = !Z & (N == V), 15 = Z | (N != V).
- R5: In plain mode (mode_loop_i = 0), take_o equals the condition result, reg_we_o is 0, and reg_o equals the sampled reg_i.
- R6: In loop mode with a true condition, take_o = 0, reg_we_o = 0, and reg_o equals the sampled reg_i.
- R7: In loop mode with a false condition, reg_we_o = 1 and reg_o = {reg_i[31:16], reg_i[15:0] - 1}. The low half wraps from 0x0000 to 0xFFFF without affecting the upper half.
- R8: In loop mode with a false condition, take_o = 1 unless the new low half equals 0xFFFF, in which case take_o = 0.
- R9: Results appear in the cycle after the start strobe. In any cycle not preceded by a start, take_o and reg_we_o are 0, and cond_true_o and reg_o keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Samples the inputs and requests an evaluation |
| mode_loop_i | input | 1 | 0 selects plain conditional branch, 1 selects loop-counter branch |
| cond_i | input | 4 | Condition selector, 0 to 15 |
| flags_i | input | 4 | Flags {N,Z,V,C} |
| reg_i | input | 32 | Counter register value |
| cond_true_o | output | 1 | Result of the selected test |
| take_o | output | 1 | Branch taken |
| reg_o | output | 32 | Register value to write back |
| reg_we_o | output | 1 | Register write enable |

## Verification
The hardest case to reach is the loop exit through counter wrap. It needs loop mode, a condition that is false, and a low half of exactly zero, with upper bits set so that any borrow into them would show. The stimulus forces this with the never selector and a counter of 0xA5A50000. A second case, 0x12340001, takes the low half to zero, which must still branch. All 16 selectors are swept over all 16 flag patterns, so that every signed combination of N and V appears.

// File: rtl/cond_pkg.sv
package cond_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_ALWAYS = 4'd0,
        SEL_NEVER  = 4'd1,
        SEL_HIGHER = 4'd2,
        SEL_LOWSAM = 4'd3,
        SEL_NOCARY = 4'd4,
        SEL_CARRY  = 4'd5,
        SEL_NOTEQ  = 4'd6,
        SEL_EQUAL  = 4'd7,
        SEL_NOOVF  = 4'd8,
        SEL_OVF    = 4'd9,
        SEL_PLUS   = 4'd10,
        SEL_MINUS  = 4'd11,
        SEL_GREQ   = 4'd12,
        SEL_LESS   = 4'd13,
        SEL_GRTR   = 4'd14,
        SEL_LSEQ   = 4'd15
    } cond_sel_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } ccr_t;

    typedef enum logic {
        MODE_PLAIN = 1'b0,
        MODE_LOOP  = 1'b1
    } br_mode_e;

    function automatic logic cond_test(input cond_sel_e sel, input ccr_t f);
        logic same_sign;
        logic r;
        same_sign = ~(f.neg ^ f.ovf);
        unique case (sel)
            SEL_ALWAYS: r = 1'b1;
            SEL_NEVER:  r = 1'b0;
            SEL_HIGHER: r = ~f.carry & ~f.zero;
            SEL_LOWSAM: r = f.carry | f.zero;
            SEL_NOCARY: r = ~f.carry;
            SEL_CARRY:  r = f.carry;
            SEL_NOTEQ:  r = ~f.zero;
            SEL_EQUAL:  r = f.zero;
            SEL_NOOVF:  r = ~f.ovf;
            SEL_OVF:    r = f.ovf;
            SEL_PLUS:   r = ~f.neg;
            SEL_MINUS:  r = f.neg;
            SEL_GREQ:   r = same_sign;
            SEL_LESS:   r = ~same_sign;
            SEL_GRTR:   r = ~f.zero & same_sign;
            default:    r = f.zero | ~same_sign;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import cond_pkg::*;
(
    input  cond_sel_e sel_i,
    input  ccr_t      ccr_i,
    output logic      hit_o
);
    always_comb begin
        hit_o = cond_test(sel_i, ccr_i);
    end
endmodule

// File: rtl/count_step.sv
module count_step #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [DATA_W-1:0] val_i,
    output logic [DATA_W-1:0] val_o,
    output logic              expired_o
);
    logic [CNT_W-1:0] low_dec;

    always_comb begin
        low_dec   = val_i[CNT_W-1:0] - CNT_W'(1);
        expired_o = &low_dec;
    end

    assign val_o[CNT_W-1:0] = low_dec;

    generate
        if (DATA_W > CNT_W) begin : g_upper
            assign val_o[DATA_W-1:CNT_W] = val_i[DATA_W-1:CNT_W];
        end
    endgenerate
endmodule

// File: rtl/cond_loop_branch.sv
module cond_loop_branch
    import cond_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              mode_loop_i,
    input  logic [3:0]        cond_i,
    input  logic [3:0]        flags_i,
    input  logic [DATA_W-1:0] reg_i,
    output logic              cond_true_o,
    output logic              take_o,
    output logic [DATA_W-1:0] reg_o,
    output logic              reg_we_o
);
    typedef struct packed {
        logic              hit;
        logic              take;
        logic              we;
        logic [DATA_W-1:0] val;
    } result_t;

    logic              hit;
    logic [DATA_W-1:0] stepped;
    logic              expired;
    br_mode_e          mode;
    result_t           nxt, cur;

    assign mode = br_mode_e'(mode_loop_i);

    cond_eval u_eval (
        .sel_i (cond_sel_e'(cond_i)),
        .ccr_i (ccr_t'(flags_i)),
        .hit_o (hit)
    );

    count_step #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_step (
        .val_i     (reg_i),
        .val_o     (stepped),
        .expired_o (expired)
    );

    always_comb begin
        nxt.hit  = hit;
        nxt.take = 1'b0;
        nxt.we   = 1'b0;
        nxt.val  = reg_i;
        if (mode == MODE_PLAIN) begin
            nxt.take = hit;
        end else if (!hit) begin
            nxt.we   = 1'b1;
            nxt.val  = stepped;
            nxt.take = ~expired;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (start_i) begin
            cur <= nxt;
        end else begin
            cur.take <= 1'b0;
            cur.we   <= 1'b0;
        end
    end

    assign cond_true_o = cur.hit;
    assign take_o      = cur.take;
    assign reg_o       = cur.val;
    assign reg_we_o    = cur.we;

    // R9: strobes only follow a start
    p_strobe_after_start_r9: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (!take_o && !reg_we_o));

    // R5: plain mode never writes the register
    p_plain_no_write_r5: assert property (@(posedge clk) disable iff (rst)
        (start_i && !mode_loop_i) |=> !reg_we_o);

    // R6: a true test in loop mode exits without touching the counter
    p_loop_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (start_i && mode_loop_i && hit) |=> (!take_o && !reg_we_o && reg_o == $past(reg_i)));

    // R7: upper half survives a decrement
    p_upper_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (start_i && mode_loop_i && !hit) |=> (reg_we_o && reg_o[DATA_W-1:CNT_W] == $past(reg_i[DATA_W-1:CNT_W])));

    // R8: no branch back once the low half reads all ones
    p_no_take_at_end_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_we_o && take_o) |-> (reg_o[CNT_W-1:0] != {CNT_W{1'b1}}));
endmodule

// File: tb/sim_cond_loop_branch.sv
module sim_cond_loop_branch;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        mode_loop_i = 1'b0;
    logic [3:0]  cond_i = '0;
    logic [3:0]  flags_i = '0;
    logic [31:0] reg_i = '0;
    logic        cond_true_o, take_o, reg_we_o;
    logic [31:0] reg_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cond_loop_branch u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_loop_i(mode_loop_i),
        .cond_i(cond_i), .flags_i(flags_i), .reg_i(reg_i),
        .cond_true_o(cond_true_o), .take_o(take_o), .reg_o(reg_o), .reg_we_o(reg_we_o)
    );

    function automatic logic model(input int sel, input logic [3:0] f);
        logic n, z, v, c;
        n = f[3]; z = f[2]; v = f[1]; c = f[0];
        case (sel)
            0: return 1'b1;
            1: return 1'b0;
            2: return !c && !z;
            3: return c || z;
            4: return !c;
            5: return c;
            6: return !z;
            7: return z;
            8: return !v;
            9: return v;
            10: return !n;
            11: return n;
            12: return n == v;
            13: return n != v;
            14: return !z && (n == v);
            default: return z || (n != v);
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fire(input logic m, input int sel, input logic [3:0] f, input logic [31:0] r);
        @(negedge clk);
        start_i = 1'b1; mode_loop_i = m; cond_i = sel[3:0]; flags_i = f; reg_i = r;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 cond", {31'd0, cond_true_o}, 0);
        check("R1 take", {31'd0, take_o}, 0);
        check("R1 we", {31'd0, reg_we_o}, 0);
        check("R1 reg", reg_o, 0);
    endtask

    task automatic t_fixed;
        for (int f = 0; f < 16; f++) begin
            fire(1'b0, 0, f[3:0], 32'h0);
            check("R2 always", {31'd0, cond_true_o}, 1);
            fire(1'b0, 1, f[3:0], 32'h0);
            check("R2 never", {31'd0, cond_true_o}, 0);
        end
    endtask

    task automatic t_sweep;
        for (int s = 2; s < 16; s++) begin
            for (int f = 0; f < 16; f++) begin
                fire(1'b0, s, f[3:0], 32'h0);
                if (s < 12) check("R3 flag test", {31'd0, cond_true_o}, {31'd0, model(s, f[3:0])});
                else        check("R4 signed test", {31'd0, cond_true_o}, {31'd0, model(s, f[3:0])});
            end
        end
    endtask

    task automatic t_plain;
        fire(1'b0, 7, 4'b0100, 32'hDEAD0000);
        check("R5 take", {31'd0, take_o}, 1);
        check("R5 we", {31'd0, reg_we_o}, 0);
        check("R5 reg", reg_o, 32'hDEAD0000);
        fire(1'b0, 7, 4'b0000, 32'h00000005);
        check("R5 not taken", {31'd0, take_o}, 0);
        check("R5 we2", {31'd0, reg_we_o}, 0);
    endtask

    task automatic t_loop_true;
        fire(1'b1, 0, 4'b0000, 32'h00000000);
        check("R6 take", {31'd0, take_o}, 0);
        check("R6 we", {31'd0, reg_we_o}, 0);
        check("R6 reg", reg_o, 32'h00000000);
        fire(1'b1, 14, 4'b0000, 32'h77770003);
        check("R6 gt exit", {31'd0, take_o | reg_we_o}, 0);
        check("R6 reg2", reg_o, 32'h77770003);
    endtask

    task automatic t_loop_dec;
        fire(1'b1, 1, 4'b1111, 32'h12340005);
        check("R7 reg", reg_o, 32'h12340004);
        check("R7 we", {31'd0, reg_we_o}, 1);
        check("R8 take", {31'd0, take_o}, 1);
        fire(1'b1, 6, 4'b0100, 32'h12340001);
        check("R7 to zero", reg_o, 32'h12340000);
        check("R8 take at zero", {31'd0, take_o}, 1);
    endtask

    task automatic t_loop_wrap;
        fire(1'b1, 1, 4'b0000, 32'hA5A50000);
        check("R7 wrap reg", reg_o, 32'hA5A5FFFF);
        check("R7 wrap we", {31'd0, reg_we_o}, 1);
        check("R8 exit", {31'd0, take_o}, 0);
    endtask

    task automatic t_timing;
        fire(1'b1, 1, 4'b0000, 32'h0000_0010);
        check("R9 first", {31'd0, take_o & reg_we_o}, 1);
        @(negedge clk);
        check("R9 take drops", {31'd0, take_o}, 0);
        check("R9 we drops", {31'd0, reg_we_o}, 0);
        check("R9 reg holds", reg_o, 32'h0000_000F);
        check("R9 cond holds", {31'd0, cond_true_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_fixed;
        t_sweep;
        t_plain;
        t_loop_true;
        t_loop_dec;
        t_loop_wrap;
        t_timing;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule